// File: doc/BRIEF.md
# Decode Stage Operand Fetch and Register File

This block sits in the decode stage of a single-cycle 32-bit load/store processor. It slices the incoming instruction word into its two source register specifiers and its 16-bit immediate. It reads two operands from a 32-entry register file and widens the immediate to a signed 32-bit operand for the execute stage.

The same block closes the write-back loop. It picks the destination register from one of two instruction fields under a control bit. It picks the write data from either the data-memory return or the ALU result. It commits that data on the rising clock edge when the write enable is high. Register 0 is hard-wired to zero.

Fetch, the ALU, the main control decoder and data memory sit outside this block. They supply the instruction, the two candidate write-back values and the three control bits.

Top module: `idecode_regfile`

## Requirements
- R1: Operand A is the register selected by instruction bits 25:21, and operand B is the register selected by bits 20:16.
- R2: Reads are combinational. An operand follows a change of the instruction within the same cycle. A value written at a rising edge is seen by reads only after that edge, and a read in the writing cycle returns the old value.
- R3: With `dest_sel_rd` = 1 the destination is bits 15:11 of the instruction. With 0 it is bits 20:16.
- R4: With `wb_from_mem` = 1 the written value is `mem_rdata`. With 0 it is `alu_result`.
- R5: A register changes only at a rising edge with `reg_wr_en` = 1. With `reg_wr_en` = 0 no register changes, even when the destination field and data are valid.
- R6: Register 0 always reads as zero. A write aimed at it leaves every register unchanged.
- R7: `imm_ext` equals bits 15:0 of the instruction with bit 15 copied into bits 31:16.
- R8: Driving `rst_n` low clears all registers to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register writes on the rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| instr | input | 32 | Instruction word being decoded |
| mem_rdata | input | 32 | Load data returned by data memory |
| alu_result | input | 32 | Result from the execute stage |
| reg_wr_en | input | 1 | Enables the register-file write |
| wb_from_mem | input | 1 | Selects memory data (1) or ALU result (0) for write-back |
| dest_sel_rd | input | 1 | Selects bits 15:11 (1) or 20:16 (0) as destination |
| opnd_a | output | 32 | Register read through bits 25:21 |
| opnd_b | output | 32 | Register read through bits 20:16 |
| imm_ext | output | 32 | Sign-extended 16-bit immediate |

## Verification
On every cycle, the assertions check four things. An enabled write to a nonzero register lands with the chosen data by the next cycle. The whole file holds still when the enable is low or when the destination is register 0. Both read ports return zero for specifier 0. Some behaviours can only be shown by the bench's scenarios, because they compare against values the bench computes itself. These are the choice of destination field and data source, the old-value read in the writing cycle, the same-cycle response of the read ports, the sign extension, and the clearing by an asynchronous reset between edges.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int INSTR_W  = 32;
  localparam int SPEC_W   = 5;
  localparam int IMM_W    = 16;
  // field positions inside the instruction word
  localparam int SRC_A_LSB = 21;
  localparam int SRC_B_LSB = 16;
  localparam int DST_R_LSB = 11;

  typedef struct packed {
    logic [SPEC_W-1:0] src_a;
    logic [SPEC_W-1:0] src_b;
    logic [SPEC_W-1:0] dst_r;
    logic [IMM_W-1:0]  imm;
  } fields_t;
endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output fields_t            flds,
  output logic [DATA_W-1:0]  imm_ext
);
  localparam int EXT_W = DATA_W - IMM_W;

  always_comb begin
    flds.src_a = instr[SRC_A_LSB +: SPEC_W];
    flds.src_b = instr[SRC_B_LSB +: SPEC_W];
    flds.dst_r = instr[DST_R_LSB +: SPEC_W];
    flds.imm   = instr[IMM_W-1:0];
  end

  assign imm_ext = {{EXT_W{flds.imm[IMM_W-1]}}, flds.imm};
endmodule

// File: rtl/idec_wb_sel.sv
module idec_wb_sel #(
  parameter int DATA_W = 32,
  parameter int AW     = 5
) (
  input  logic [AW-1:0]     spec_rt,
  input  logic [AW-1:0]     spec_rd,
  input  logic              dest_sel_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              wb_from_mem,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  always_comb begin
    wr_addr = dest_sel_rd ? spec_rd : spec_rt;
    wr_data = wb_from_mem ? mem_rdata : alu_result;
  end
endmodule

// File: rtl/idec_regfile.sv
module idec_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);
  // register 0 has no storage; its slot in the view is a constant zero
  logic [NREG-1:1][DATA_W-1:0] regs_q;
  logic [NREG-1:0][DATA_W-1:0] view;
  logic [NREG-1:1]             wr_hit;

  assign view = {regs_q, {DATA_W{1'b0}}};

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_comb wr_hit[g] = wr_en && (wr_addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_hit[g]) begin
        regs_q[g] <= wr_data;
      end
    end
  end

  assign rd_data_a = view[rd_addr_a];
  assign rd_data_b = view[rd_addr_b];

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0) |=> view[$past(wr_addr)] == $past(wr_data));

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));

  assert_zero_dest_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |=> $stable(regs_q));
endmodule

// File: rtl/idecode_regfile.sv
module idecode_regfile
  import idec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              reg_wr_en,
  input  logic              wb_from_mem,
  input  logic              dest_sel_rd,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] imm_ext
);
  localparam int AW = $clog2(NREG);

  fields_t             flds;
  logic [AW-1:0]       wr_addr;
  logic [DATA_W-1:0]   wr_data;

  idec_fields #(.DATA_W(DATA_W)) u_fields (
    .instr   (instr),
    .flds    (flds),
    .imm_ext (imm_ext)
  );

  idec_wb_sel #(.DATA_W(DATA_W), .AW(AW)) u_wb (
    .spec_rt     (AW'(flds.src_b)),
    .spec_rd     (AW'(flds.dst_r)),
    .dest_sel_rd (dest_sel_rd),
    .mem_rdata   (mem_rdata),
    .alu_result  (alu_result),
    .wb_from_mem (wb_from_mem),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
  );

  idec_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (AW'(flds.src_a)),
    .rd_addr_b (AW'(flds.src_b)),
    .rd_data_a (opnd_a),
    .rd_data_b (opnd_b)
  );

  assert_zero_read_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[25:21] == 5'd0) |-> opnd_a == '0);

  assert_zero_read_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[20:16] == 5'd0) |-> opnd_b == '0);
endmodule

// File: tb/sim_idecode_regfile.sv
module sim_idecode_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] alu_result = '0;
  logic        reg_wr_en = 1'b0;
  logic        wb_from_mem = 1'b0;
  logic        dest_sel_rd = 1'b0;
  logic [31:0] opnd_a, opnd_b, imm_ext;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  idecode_regfile u0 (
    .clk(clk), .rst_n(rst_n), .instr(instr), .mem_rdata(mem_rdata),
    .alu_result(alu_result), .reg_wr_en(reg_wr_en), .wb_from_mem(wb_from_mem),
    .dest_sel_rd(dest_sel_rd), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_ext(imm_ext)
  );

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] mem;
    logic [31:0] alu;
    logic        we;
    logic        m2r;
    logic        dst;
    logic [31:0] exp_a;
    logic [31:0] exp_b;
  } vec_t;

  // expected operands are those read before the vector's own write edge
  localparam vec_t VECS [10] = '{
    '{ {6'd35, 5'd0, 5'd3, 16'h8004},             32'hDEADBEEF, 32'h0,        1'b1, 1'b1, 1'b0, 32'h0,        32'h0        },
    '{ {6'd0, 5'd3, 5'd0, 5'd5, 5'd0, 6'd32},     32'h11111111, 32'h22222222, 1'b1, 1'b0, 1'b1, 32'hDEADBEEF, 32'h0        },
    '{ {6'd0, 5'd5, 5'd3, 5'd7, 5'd0, 6'd34},     32'hAAAA0000, 32'h12345678, 1'b0, 1'b0, 1'b1, 32'h22222222, 32'hDEADBEEF },
    '{ {6'd0, 5'd7, 5'd5, 5'd0, 5'd0, 6'd32},     32'h0,        32'h5555AAAA, 1'b1, 1'b0, 1'b1, 32'h0,        32'h22222222 },
    '{ {6'd8, 5'd0, 5'd0, 16'h7FFF},              32'h0,        32'hCAFEF00D, 1'b1, 1'b0, 1'b0, 32'h0,        32'h0        },
    '{ {6'd35, 5'd5, 5'd31, 16'h0000},            32'h87654321, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 32'h22222222, 32'h0        },
    '{ {6'd0, 5'd31, 5'd31, 5'd31, 5'd0, 6'd37},  32'h0,        32'h0F0F0F0F, 1'b1, 1'b0, 1'b1, 32'h87654321, 32'h87654321 },
    '{ {6'd0, 5'd31, 5'd3, 5'd3, 5'd0, 6'd32},    32'h13579BDF, 32'h2468ACE0, 1'b1, 1'b1, 1'b1, 32'h0F0F0F0F, 32'hDEADBEEF },
    '{ {6'd43, 5'd3, 5'd0, 16'hFFFF},             32'h0,        32'h0,        1'b0, 1'b0, 1'b0, 32'h13579BDF, 32'h0        },
    '{ {6'd4, 5'd5, 5'd31, 16'h0001},             32'h0,        32'h0,        1'b0, 1'b0, 1'b0, 32'h22222222, 32'h0F0F0F0F }
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(input logic [31:0] w);
    return {{16{w[15]}}, w[15:0]};
  endfunction

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state: R8
    instr = {6'd0, 5'd3, 5'd31, 16'h0};
    #1;
    check("R8 reset clears port A", opnd_a, 32'h0);
    check("R8 reset clears port B", opnd_b, 32'h0);

    // table walk: R1 R2 R3 R4 R5 R6 R7
    foreach (VECS[i]) begin
      @(negedge clk);
      instr       = VECS[i].ins;
      mem_rdata   = VECS[i].mem;
      alu_result  = VECS[i].alu;
      reg_wr_en   = VECS[i].we;
      wb_from_mem = VECS[i].m2r;
      dest_sel_rd = VECS[i].dst;
      #1;
      check($sformatf("R1 vector %0d operand A", i), opnd_a, VECS[i].exp_a);
      check($sformatf("R1 vector %0d operand B", i), opnd_b, VECS[i].exp_b);
      check($sformatf("R7 vector %0d immediate", i), imm_ext, sext(VECS[i].ins));
    end

    // R2: operand follows instruction change inside one cycle
    @(negedge clk);
    reg_wr_en = 1'b0;
    instr = {6'd0, 5'd3, 5'd5, 16'h0};
    #1;
    check("R2 same-cycle read A", opnd_a, 32'h13579BDF);
    instr = {6'd0, 5'd31, 5'd5, 16'h0};
    #1;
    check("R2 same-cycle read A after change", opnd_a, 32'h0F0F0F0F);

    // R4 and R3: ALU result through rt destination, then visible after edge
    @(negedge clk);
    instr = {6'd8, 5'd9, 5'd9, 16'h5000};
    alu_result = 32'h600DCAFE; mem_rdata = 32'hBAD0BAD0;
    wb_from_mem = 1'b0; dest_sel_rd = 1'b0; reg_wr_en = 1'b1;
    #1;
    check("R2 old value in writing cycle", opnd_b, 32'h0);
    @(negedge clk);
    reg_wr_en = 1'b0;
    #1;
    check("R3 rt destination written with R4 ALU data", opnd_b, 32'h600DCAFE);
    instr = {6'd0, 5'd10, 5'd10, 16'h0};
    #1;
    check("R3 rd field (r10) untouched by rt write", opnd_a, 32'h0);

    // R8: asynchronous clear between edges
    @(negedge clk);
    instr = {6'd0, 5'd9, 5'd3, 16'h0};
    #1;
    rst_n = 1'b0;
    #1;
    check("R8 async clear port A", opnd_a, 32'h0);
    check("R8 async clear port B", opnd_b, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule